// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a full-duplex SPI master for serial NOR flash. The host hands it one command at a time: a command kind, a 24-bit address and a byte count. The block then builds the whole bus transaction. It sends the opcode and address, the 0xFF filler bytes that clock read data in, and program data taken from a transmit FIFO. Each command gets its own chip-select low period.

Every byte shifted out brings one byte back, so the host never sees the reply bytes that arrive during the header, or any reply during program or erase commands. Only the real read-data bytes go into a receive FIFO. If a byte arrives while that FIFO is full, the byte is dropped and a sticky overflow flag is set.

The bus runs in SPI mode 0, MSB first. SCLK is derived from the system clock by a divider. Both the divider and the minimum chip-select high time are inputs. Command kind codes are: 0 read (0x03), 1 write enable (0x06), 2 page program (0x02), 3 sector erase (0x20), 4 block erase (0xD8). Codes 5 to 7 are treated as write enable. FIFO depths must be powers of two.

Top module: `spi_flash_seq`

## Requirements
- R1: A read (kind 0) sends opcode 0x03, then the three address bytes with the most significant byte first. Each byte goes out MSB first in SPI mode 0: MOSI changes while SCLK is low, and MISO is sampled on the SCLK rising edge.
- R2: A read of N bytes sends exactly N filler bytes of 0xFF after the header, so chip select stays low for exactly 4+N bytes. N = 0 sends only the header.
- R3: The four reply bytes received during the read header are dropped. The receive FIFO gets exactly the N bytes received during the filler phase, in arrival order.
- R4: Write enable (kind 1) is the single byte 0x06. Sector erase (kind 3) and block erase (kind 4) are opcode 0x20 or 0xD8 followed by the three address bytes, with no data phase. None of these puts anything in the receive FIFO.
- R5: Page program (kind 2) with N bytes (1 to 256) sends 0x02, the address, then N bytes popped from the transmit FIFO in order. Reply bytes are dropped. If the transmit FIFO is empty when a data byte is due, SCLK stays low and chip select stays low until a byte is written.
- R6: Each command occupies exactly one chip-select low period. While chip select is high, SCLK stays low. The MSB of the opcode is on MOSI from the chip-select falling edge, and no SCLK edge comes before the opcode.
- R7: After chip select rises, `cmd_ready` stays low for `cs_gap` system clocks. Chip select therefore stays high for at least `cs_gap` clocks, and at least one clock, between commands.
- R8: `busy` is high from the clock after a command is accepted until chip select returns high. It is low exactly when chip select is high.
- R9: A read-data byte that arrives while the receive FIFO is full is lost, and the bytes already stored are kept. `rx_overflow` rises and stays high until reset.
- R10: Each SCLK high and low phase lasts `clk_div`+1 system clocks. SCLK idles low.
- R11: After reset: chip select is high, SCLK is low, `busy` and `rx_overflow` are low, the receive FIFO is empty and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | SCLK half period minus one, in system clocks |
| cs_gap | input | GAP_W | Minimum chip-select high time in system clocks |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_kind | input | 3 | Command kind code |
| cmd_addr | input | 24 | Flash address |
| cmd_len | input | 9 | Data byte count for read or program |
| busy | output | 1 | Command in progress |
| tx_wr | input | 1 | Push program data byte |
| tx_data | input | 8 | Program data byte |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Pop receive byte |
| rx_data | output | 8 | Head of receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The flash model in the bench returns a byte value that is a function of the byte's position within the chip-select period. A receive FIFO that held a header reply, or missed a data byte, therefore shows a shifted value instead of a plausible one.

Reads are run with lengths of 0, 5 and more than the FIFO depth. These separate the filler count, the header drop and the overflow loss. Program commands are run with data already queued and with data written late, which separates normal streaming from the stall path. Back-to-back write enables and erases with a large chip-select gap, and a read with a slower divider, check framing and timing separately from content.

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  parameter int TX_DEPTH = 256,
  parameter int RX_DEPTH = 16,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_PROG = 8'h02,
  parameter logic [7:0] OP_SE = 8'h20,
  parameter logic [7:0] OP_BE = 8'hD8,
  parameter logic [7:0] FILL = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [GAP_W-1:0] cs_gap,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_kind,
  input  logic [23:0]      cmd_addr,
  input  logic [8:0]       cmd_len,
  output logic             busy,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_overflow,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int TXA = $clog2(TX_DEPTH);
  localparam int RXA = $clog2(RX_DEPTH);
  localparam int IW = 10;
  localparam logic [2:0] K_READ = 3'd0, K_PROG = 3'd2, K_SE = 3'd3, K_BE = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_WAIT, S_FIN} st_t;

  st_t              st;
  logic [2:0]       kind;
  logic [23:0]      addr;
  logic [8:0]       len;
  logic [IW-1:0]    idx;
  logic [DIV_W-1:0] dcnt;
  logic [GAP_W-1:0] gap;
  logic [2:0]       bitc;
  logic [7:0]       sh, rsh;

  logic [7:0]     tx_mem [TX_DEPTH];
  logic [TXA-1:0] tx_wp, tx_rp;
  logic [TXA:0]   tx_cnt;
  logic [7:0]     rx_mem [RX_DEPTH];
  logic [RXA-1:0] rx_wp, rx_rp;
  logic [RXA:0]   rx_cnt;

  function automatic logic [7:0] op_of(input logic [2:0] k);
    case (k)
      K_READ:  op_of = OP_READ;
      K_PROG:  op_of = OP_PROG;
      K_SE:    op_of = OP_SE;
      K_BE:    op_of = OP_BE;
      default: op_of = OP_WREN;
    endcase
  endfunction

  wire is_rd  = kind == K_READ;
  wire is_pp  = kind == K_PROG;
  wire has_ad = is_rd || is_pp || kind == K_SE || kind == K_BE;
  wire [IW-1:0] hdr_len = has_ad ? IW'(4) : IW'(1);
  wire [IW-1:0] total = hdr_len + ((is_rd || is_pp) ? IW'(len) : IW'(0));
  wire [IW-1:0] nxt = idx + IW'(1);
  wire last = nxt == total;
  wire nxt_data = nxt >= hdr_len;
  wire tick = dcnt == clk_div;
  wire bnd = st == S_SHIFT && tick && spi_sclk && bitc == 3'd7;

  wire tx_empty = tx_cnt == '0;
  wire [7:0] tx_head = tx_mem[tx_rp];
  wire rx_full = rx_cnt == (RXA+1)'(RX_DEPTH);

  logic [7:0] nxt_byte;
  always_comb begin
    case (nxt[1:0])
      2'd1:    nxt_byte = addr[23:16];
      2'd2:    nxt_byte = addr[15:8];
      default: nxt_byte = addr[7:0];
    endcase
    if (nxt_data) nxt_byte = is_pp ? tx_head : FILL;
  end

  wire tx_pop = (bnd && !last && is_pp && nxt_data && !tx_empty) ||
                (st == S_WAIT && !tx_empty);
  wire tx_push = tx_wr && !tx_full;
  wire rx_push = bnd && is_rd && idx >= IW'(4);
  wire rx_pop = rx_rd && rx_valid;

  assign cmd_ready = st == S_IDLE && gap == '0;
  assign busy = st != S_IDLE;
  assign spi_mosi = !spi_cs_n && sh[7];
  assign tx_full = tx_cnt == (TXA+1)'(TX_DEPTH);
  assign rx_valid = rx_cnt != '0;
  assign rx_data = rx_mem[rx_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind <= '0;
      addr <= '0;
      len <= '0;
      idx <= '0;
      dcnt <= '0;
      gap <= '0;
      bitc <= '0;
      sh <= '0;
      rsh <= '0;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (gap != '0) gap <= gap - 1'b1;
          if (cmd_valid && cmd_ready) begin
            kind <= cmd_kind;
            addr <= cmd_addr;
            len <= cmd_len;
            idx <= '0;
            bitc <= '0;
            dcnt <= '0;
            sh <= op_of(cmd_kind);
            spi_cs_n <= 1'b0;
            st <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!tick) dcnt <= dcnt + 1'b1;
          else begin
            dcnt <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
              rsh <= {rsh[6:0], spi_miso};
            end else begin
              spi_sclk <= 1'b0;
              if (bitc != 3'd7) begin
                bitc <= bitc + 1'b1;
                sh <= {sh[6:0], 1'b0};
              end else begin
                bitc <= '0;
                if (last) st <= S_FIN;
                else begin
                  idx <= nxt;
                  if (is_pp && nxt_data && tx_empty) st <= S_WAIT;
                  else sh <= nxt_byte;
                end
              end
            end
          end
        end
        S_WAIT: begin
          dcnt <= '0;
          if (!tx_empty) begin
            sh <= tx_head;
            st <= S_SHIFT;
          end
        end
        S_FIN: begin
          if (!tick) dcnt <= dcnt + 1'b1;
          else begin
            dcnt <= '0;
            spi_cs_n <= 1'b1;
            gap <= cs_gap;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) begin
        tx_mem[tx_wp] <= tx_data;
        tx_wp <= tx_wp + 1'b1;
      end
      if (tx_pop) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (TXA+1)'(tx_push) - (TXA+1)'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0;
      rx_rp <= '0;
      rx_cnt <= '0;
      rx_overflow <= 1'b0;
    end else begin
      if (rx_push && !rx_full) begin
        rx_mem[rx_wp] <= rsh;
        rx_wp <= rx_wp + 1'b1;
      end
      if (rx_push && rx_full) rx_overflow <= 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (RXA+1)'(rx_push && !rx_full) - (RXA+1)'(rx_pop);
    end
  end

  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  a_r6_fresh_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sclk && $past(!spi_sclk));
  a_r8_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !spi_cs_n);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_overflow) |-> rx_overflow);
  a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= (RXA+1)'(RX_DEPTH));
  a_r7_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_cs_n) && cs_gap != '0) |-> !cmd_ready);
  a_r5_stall_low: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT |-> !spi_sclk && !spi_cs_n);
endmodule

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] clk_div = 8'd1, cs_gap = 8'd2;
  logic cmd_valid = 0, cmd_ready, busy;
  logic [2:0] cmd_kind = 0;
  logic [23:0] cmd_addr = 0;
  logic [8:0] cmd_len = 0;
  logic tx_wr = 0, tx_full, rx_rd = 0, rx_valid, rx_overflow;
  logic [7:0] tx_data = 0, rx_data;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_flash_seq dut_i (.*);

  function automatic logic [7:0] fval(input int k);
    return 8'(8'h40 + k);
  endfunction

  logic [7:0] rec [0:599];
  int nrec = 0, scnt = 0, sidx = 0, cs_falls = 0, sclk_hi_cs = 0;
  logic [7:0] sin, sout;

  always @(negedge spi_cs_n) begin
    nrec = 0; scnt = 0; sidx = 0; cs_falls++;
    sout = fval(0); spi_miso = sout[7];
  end
  always @(posedge spi_sclk) begin
    if (spi_cs_n) sclk_hi_cs++;
    else begin
      sin = {sin[6:0], spi_mosi}; scnt++;
      if (scnt == 8) begin rec[nrec] = sin; nrec++; scnt = 0; sidx++; end
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (scnt == 0) begin sout = fval(sidx); spi_miso = sout[7]; end
    else spi_miso = sout[7-scnt];
  end

  int cyc = 0, last_rise = 0, period = 0, hi = 1000, last_hi = 0;
  logic prev_sclk = 0, prev_cs = 1;
  always @(negedge clk) begin
    cyc++;
    if (spi_sclk && !prev_sclk) begin period = cyc - last_rise; last_rise = cyc; end
    prev_sclk = spi_sclk;
    if (!spi_cs_n && prev_cs) last_hi = hi;
    if (spi_cs_n) hi++; else hi = 0;
    prev_cs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [23:0] a, input int n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_kind = k; cmd_addr = a; cmd_len = 9'(n); cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy && !spi_cs_n, "R8 busy after accept", busy, 1);
  endtask

  task automatic finish_cmd;
    while (busy) @(negedge clk);
    chk(spi_cs_n, "R8 cs high when busy drops", spi_cs_n, 1);
  endtask

  task automatic chk_hdr(input logic [7:0] op, input logic [23:0] a, input string tag);
    chk(rec[0] == op, {tag, " opcode"}, rec[0], op);
    chk(rec[1] == a[23:16] && rec[2] == a[15:8] && rec[3] == a[7:0], {tag, " address"},
        {rec[1], rec[2], rec[3]}, a);
  endtask

  task automatic pop_expect(input int n, input int base, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(rx_valid && rx_data == fval(base + i), tag, rx_data, fval(base + i));
      rx_rd = 1; @(negedge clk); rx_rd = 0;
    end
    chk(!rx_valid, {tag, " no extra bytes"}, rx_valid, 0);
  endtask

  task automatic t_reset;
    chk(spi_cs_n && !spi_sclk && !busy && !rx_overflow && !rx_valid && cmd_ready,
        "R11 reset state", {spi_cs_n, spi_sclk, busy, rx_overflow, rx_valid, cmd_ready}, 6'b100001);
  endtask

  task automatic t_read5;
    int bad = 0;
    issue(3'd0, 24'h123456, 5); finish_cmd;
    chk_hdr(8'h03, 24'h123456, "R1 read");
    chk(nrec == 9, "R2 read byte count", nrec, 9);
    for (int i = 4; i < 9; i++) if (rec[i] != 8'hFF) bad++;
    chk(bad == 0, "R2 filler bytes", bad, 0);
    pop_expect(5, 4, "R3 read data");
  endtask

  task automatic t_read0;
    issue(3'd0, 24'hABCDEF, 0); finish_cmd;
    chk(nrec == 4, "R2 zero length read", nrec, 4);
    chk_hdr(8'h03, 24'hABCDEF, "R1 read0");
    chk(!rx_valid, "R3 header replies dropped", rx_valid, 0);
  endtask

  task automatic t_wren_erase;
    int f0;
    cs_gap = 8'd20;
    f0 = cs_falls;
    issue(3'd1, 24'h0, 0); finish_cmd;
    chk(nrec == 1 && rec[0] == 8'h06, "R4 write enable", rec[0], 8'h06);
    issue(3'd3, 24'h00F000, 7); finish_cmd;
    chk(nrec == 4, "R4 sector erase length", nrec, 4);
    chk_hdr(8'h20, 24'h00F000, "R4 sector erase");
    chk(last_hi >= 20, "R7 cs high gap", last_hi, 20);
    issue(3'd4, 24'h7F0000, 0); finish_cmd;
    chk(nrec == 4, "R4 block erase length", nrec, 4);
    chk_hdr(8'hD8, 24'h7F0000, "R4 block erase");
    chk(!rx_valid, "R4 nothing received", rx_valid, 0);
    chk(cs_falls - f0 == 3, "R6 one cs pulse per command", cs_falls - f0, 3);
    cs_gap = 8'd2;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask

  task automatic t_prog;
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    issue(3'd2, 24'h000100, 3); finish_cmd;
    chk_hdr(8'h02, 24'h000100, "R5 program");
    chk(nrec == 7 && rec[4] == 8'h11 && rec[5] == 8'h22 && rec[6] == 8'h33,
        "R5 program data", {rec[4], rec[5], rec[6]}, 24'h112233);
    chk(!rx_valid, "R5 replies dropped", rx_valid, 0);
  endtask

  task automatic t_prog_stall;
    issue(3'd2, 24'h000200, 2);
    repeat (200) @(negedge clk);
    chk(busy && !spi_cs_n && !spi_sclk && nrec == 4, "R5 stall holds bus", nrec, 4);
    push_tx(8'hA5); push_tx(8'h5A);
    finish_cmd;
    chk(nrec == 6 && rec[4] == 8'hA5 && rec[5] == 8'h5A, "R5 stalled data",
        {rec[4], rec[5]}, 16'hA55A);
  endtask

  task automatic t_div;
    clk_div = 8'd3;
    issue(3'd0, 24'h000010, 1); finish_cmd;
    chk(period == 8, "R10 sclk period", period, 8);
    pop_expect(1, 4, "R10 read at slow clock");
    clk_div = 8'd1;
    issue(3'd1, 24'h0, 0); finish_cmd;
    chk(period == 4, "R10 sclk fast period", period, 4);
  endtask

  task automatic t_overflow;
    issue(3'd0, 24'h001000, 18); finish_cmd;
    chk(rx_overflow, "R9 overflow raised", rx_overflow, 1);
    issue(3'd1, 24'h0, 0); finish_cmd;
    chk(rx_overflow, "R9 overflow sticky", rx_overflow, 1);
    pop_expect(16, 4, "R9 stored bytes kept");
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    chk(!rx_overflow, "R11 reset clears overflow", rx_overflow, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_read5;
    t_read0;
    t_wren_erase;
    t_prog;
    t_prog_stall;
    t_div;
    t_overflow;
    chk(sclk_hi_cs == 0, "R6 no sclk while cs high", sclk_hi_cs, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule